// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits between a receive byte stream and system memory. It scatters each incoming frame over a ring of fixed-size receive buffers, 128 bytes each by default. Each buffer has a descriptor of two 32-bit words. The address word holds the buffer start address, an ownership flag and an end-of-ring marker. The status word is written by the block once the buffer is closed.

For each buffer the block does the following:
- It reads the address word of the current descriptor.
- It refuses the descriptor if software still owns it.
- It fills the buffer through a byte-wide write port.
- It writes the address word back with the ownership flag set.
- It writes the status word, carrying the frame-start and frame-end flags, the frame length and the match flags.

A frame longer than one buffer chains into the following descriptors. This includes crossing from the last descriptor of the ring back to descriptor 0.

If a descriptor is needed while software still owns it, the frame is discarded up to its last byte and a one-cycle overrun pulse is raised. Dropping receive enable returns the ring position to descriptor 0.

Top module: `rx_ring_writer`

## Requirements
- R1: While `rx_en` is low, `in_ready` is low, no memory access is made, and the ring position returns to descriptor 0. The first frame after enabling uses descriptor 0.
- R2: Descriptor i sits at `ring_base + 8*i`, where `ring_base` is 8-byte aligned. Its address word is at offset 0 and its status word at offset 4. The buffer starts at the address word with bits 1:0 cleared.
- R3: Only a descriptor whose address-word bit 0 (used) is clear is filled. Its address word is written back with bit 0 set, and every other bit is unchanged, including bit 1 (wrap).
- R4: A buffer takes up to 128 bytes, stored in arrival order from its start address. A longer frame continues in the next descriptor. A frame of exactly 128 bytes takes a single descriptor.
- R5: Status bit 14 (frame start) is set only in the first descriptor of a frame. Status bit 15 (frame end) is set only in the last.
- R6: The frame-end descriptor carries the total frame length in status bits 11:0. Other descriptors carry 0 there.
- R7: Match flags are sampled with the last byte and written only in the frame-end descriptor:
  - `in_bcast` goes to bit 31.
  - `in_addr_hit[k]` goes to bit 23+k.
  - `in_type_hit` goes to bit 22.
- R8: After a descriptor whose wrap bit is set, the next descriptor is descriptor 0. A frame may continue across this point.
- R9: If the descriptor needed at the start of a frame is still used, the block does the following:
  - It raises `overrun` for exactly one cycle.
  - It consumes the whole frame and writes nothing to memory.
  - It keeps its ring position, so the next frame tries the same descriptor.
- R10: If the next descriptor is still used in the middle of a frame, the buffers already closed stay written without a frame-end flag. The rest of the frame is discarded with one `overrun` pulse, and the used descriptor is left untouched.
- R11: Each address-word writeback is followed in the very next cycle by the status-word writeback of the same descriptor. A descriptor read is a single-cycle request, and `dsc_rdata` is expected one cycle later.
- R12: A byte is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a descriptor is fetched or written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low clears the ring position |
| ring_base | input | AW | Byte address of descriptor 0 |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_bcast | input | 1 | Broadcast flag, sampled with the last byte |
| in_addr_hit | input | 4 | Specific-address match flags, sampled with the last byte |
| in_type_hit | input | 1 | Type-ID match flag, sampled with the last byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| dsc_rd_en | output | 1 | Descriptor word read request |
| dsc_wr_en | output | 1 | Descriptor word write |
| dsc_addr | output | AW | Descriptor word byte address |
| dsc_wdata | output | 32 | Descriptor write data |
| dsc_rdata | input | 32 | Descriptor read data, one cycle after the request |
| buf_wr_en | output | 1 | Buffer byte write |
| buf_addr | output | AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| overrun | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
The bench targets three boundaries:
- A frame of exactly 128 bytes: a design that closes a buffer one byte early or late would split it into two descriptors or run over its buffer.
- A frame that crosses the wrap descriptor: a design that ignores the wrap bit would walk past the end of the ring, and one that rewrites the address word carelessly would lose that bit.
- Overruns at frame start and mid-frame: a wrong design would write into a software-owned descriptor, skip past it, or fail to swallow the remaining bytes, corrupting the next frame.

Disabling receive with a non-zero ring position checks that the position really returns to descriptor 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_FETCH = 3'd2,
        ST_FILL  = 3'd3,
        ST_WB_A  = 3'd4,
        ST_WB_S  = 3'd5,
        ST_DROP  = 3'd6
    } wr_state_e;

    localparam int AW_USED_BIT = 0;
    localparam int AW_WRAP_BIT = 1;
    localparam int ST_SOF_BIT  = 14;
    localparam int ST_EOF_BIT  = 15;
    localparam int ST_TYPE_BIT = 22;
    localparam int ST_HIT_LSB  = 23;
    localparam int ST_BC_BIT   = 31;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW   = 32,
    parameter int IDXW = 10
) (
    input  logic [AW-1:0]   ring_base,
    input  logic [IDXW-1:0] idx,
    input  logic            wrap,
    output logic [AW-1:0]   desc_addr,
    output logic [IDXW-1:0] idx_next
);
    // eight bytes per descriptor
    assign desc_addr = ring_base + (AW'(idx) << 3);
    assign idx_next  = wrap ? '0 : idx + 1'b1;
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt #(
    parameter int LENW = 12
) (
    input  logic [LENW-1:0] len,
    input  logic            sof,
    input  logic            eof,
    input  logic            bcast,
    input  logic [3:0]      addr_hit,
    input  logic            type_hit,
    output logic [31:0]     word
);
    import rxr_pkg::*;
    always_comb begin
        word = '0;
        word[ST_SOF_BIT] = sof;
        word[ST_EOF_BIT] = eof;
        if (eof) begin
            word[LENW-1:0]                 = len;
            word[ST_BC_BIT]                = bcast;
            word[ST_HIT_LSB+3:ST_HIT_LSB]  = addr_hit;
            word[ST_TYPE_BIT]              = type_hit;
        end
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int AW        = 32,
    parameter int IDXW      = 10,
    parameter int BUF_BYTES = 128,
    parameter int LENW      = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_bcast,
    input  logic [3:0]    in_addr_hit,
    input  logic          in_type_hit,
    output logic          in_ready,
    output logic          dsc_rd_en,
    output logic          dsc_wr_en,
    output logic [AW-1:0] dsc_addr,
    output logic [31:0]   dsc_wdata,
    input  logic [31:0]   dsc_rdata,
    output logic          buf_wr_en,
    output logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_wdata,
    output logic          overrun
);
    import rxr_pkg::*;

    localparam int OFFW = $clog2(BUF_BYTES);
    localparam logic [OFFW-1:0] OFF_LAST = OFFW'(BUF_BYTES - 1);

    typedef struct packed {
        wr_state_e       st;
        logic [IDXW-1:0] idx;
        logic [31:0]     aword;
        logic [OFFW-1:0] off;
        logic [LENW-1:0] len;
        logic            sof;
        logic            eof;
        logic            bcast;
        logic [3:0]      hit;
        logic            typ;
    } wr_regs_t;

    wr_regs_t r_d, r_q;

    logic [AW-1:0]   desc_base;
    logic [IDXW-1:0] idx_next;
    logic [31:0]     status_word;

    rxr_ring_ptr #(.AW(AW), .IDXW(IDXW)) u_ptr (
        .ring_base (ring_base),
        .idx       (r_q.idx),
        .wrap      (r_q.aword[AW_WRAP_BIT]),
        .desc_addr (desc_base),
        .idx_next  (idx_next)
    );

    rxr_status_fmt #(.LENW(LENW)) u_fmt (
        .len      (r_q.len),
        .sof      (r_q.sof),
        .eof      (r_q.eof),
        .bcast    (r_q.bcast),
        .addr_hit (r_q.hit),
        .type_hit (r_q.typ),
        .word     (status_word)
    );

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        dsc_rd_en = 1'b0;
        dsc_wr_en = 1'b0;
        dsc_addr  = desc_base;
        dsc_wdata = '0;
        buf_wr_en = 1'b0;
        buf_addr  = AW'({r_q.aword[31:2], 2'b00}) + AW'(r_q.off);
        buf_wdata = in_data;
        overrun   = 1'b0;
        if (!rx_en) begin
            r_d = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: if (in_valid) begin
                    dsc_rd_en = 1'b1;
                    r_d.st    = ST_FETCH;
                    r_d.sof   = 1'b1;
                    r_d.len   = '0;
                end
                ST_REQ: begin
                    dsc_rd_en = 1'b1;
                    r_d.st    = ST_FETCH;
                end
                ST_FETCH: begin
                    if (dsc_rdata[AW_USED_BIT]) begin
                        overrun = 1'b1;
                        r_d.st  = ST_DROP;
                    end else begin
                        r_d.aword = dsc_rdata;
                        r_d.off   = '0;
                        r_d.eof   = 1'b0;
                        r_d.st    = ST_FILL;
                    end
                end
                ST_FILL: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        buf_wr_en = 1'b1;
                        r_d.len   = r_q.len + 1'b1;
                        if (in_last) begin
                            r_d.eof   = 1'b1;
                            r_d.bcast = in_bcast;
                            r_d.hit   = in_addr_hit;
                            r_d.typ   = in_type_hit;
                            r_d.st    = ST_WB_A;
                        end else if (r_q.off == OFF_LAST) begin
                            r_d.st = ST_WB_A;
                        end else begin
                            r_d.off = r_q.off + 1'b1;
                        end
                    end
                end
                ST_WB_A: begin
                    dsc_wr_en = 1'b1;
                    dsc_wdata = r_q.aword | 32'h1;
                    r_d.st    = ST_WB_S;
                end
                ST_WB_S: begin
                    dsc_wr_en = 1'b1;
                    dsc_addr  = desc_base + AW'(4);
                    dsc_wdata = status_word;
                    r_d.sof   = 1'b0;
                    r_d.idx   = idx_next;
                    r_d.st    = r_q.eof ? ST_IDLE : ST_REQ;
                end
                ST_DROP: begin
                    in_ready = 1'b1;
                    if (in_valid && in_last) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !in_ready && !dsc_rd_en && !dsc_wr_en && !buf_wr_en);

    // R3
    used_set_on_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_wr_en && !dsc_addr[2] |-> dsc_wdata[AW_USED_BIT]);

    // R11
    status_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_wr_en && !dsc_addr[2] |=> dsc_wr_en && dsc_addr[2]);

    // R11
    read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_rd_en |=> !dsc_rd_en && !dsc_wr_en);

    // R9
    overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> !overrun && !dsc_wr_en);

    // R12
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_wr_en |-> !buf_wr_en && !in_ready);
endmodule

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
    localparam int AW = 32;
    localparam logic [31:0] BASE = 32'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_bcast = 1'b0, in_type_hit = 1'b0;
    logic [7:0] in_data = '0;
    logic [3:0] in_addr_hit = '0;
    logic in_ready, dsc_rd_en, dsc_wr_en, buf_wr_en, overrun;
    logic [AW-1:0] dsc_addr, buf_addr;
    logic [31:0] dsc_wdata, dsc_rdata;
    logic [7:0] buf_wdata;

    logic [31:0] dmem [0:63];
    logic [7:0]  bmem [0:2047];
    int n_chk = 0, n_bad = 0;
    int ovr_cnt = 0, dwr_cnt = 0, bwr_cnt = 0, seq_err = 0;
    logic prev_aw = 1'b0;

    always #10 clk = ~clk;

    rx_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(BASE),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_bcast(in_bcast), .in_addr_hit(in_addr_hit), .in_type_hit(in_type_hit),
        .in_ready(in_ready), .dsc_rd_en(dsc_rd_en), .dsc_wr_en(dsc_wr_en),
        .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
        .buf_wr_en(buf_wr_en), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .overrun(overrun)
    );

    always @(posedge clk) begin
        if (dsc_rd_en) dsc_rdata <= dmem[dsc_addr[7:2]];
        if (dsc_wr_en) begin dmem[dsc_addr[7:2]] <= dsc_wdata; dwr_cnt <= dwr_cnt + 1; end
        if (buf_wr_en) begin bmem[buf_addr[10:0]] <= buf_wdata; bwr_cnt <= bwr_cnt + 1; end
        if (overrun) ovr_cnt <= ovr_cnt + 1;
        if (rst_n && prev_aw && !(dsc_wr_en && dsc_addr[2])) seq_err <= seq_err + 1;
        prev_aw <= dsc_wr_en && !dsc_addr[2];
    end

    function automatic logic [31:0] bufa(input int i);
        return 32'h400 + 32'(i) * 32'h80;
    endfunction
    function automatic int aw_ix(input int i);
        return int'((BASE >> 2) + 32'(2 * i));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic release_desc(input int i);
        dmem[aw_ix(i)][0] = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = last;
        forever begin
            logic r;
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input int n, input int seed, input logic bc,
                              input logic [3:0] hit, input logic ty);
        in_bcast = bc; in_addr_hit = hit; in_type_hit = ty;
        for (int k = 0; k < n; k++) send_byte(8'(seed + k), k == n - 1);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic chk_desc(input string req, input int i, input logic sof, input logic eof,
                            input int len, input logic bc, input logic [3:0] hit, input logic ty);
        logic [31:0] st;
        st = '0;
        st[14] = sof; st[15] = eof;
        if (eof) begin st[11:0] = 12'(len); st[31] = bc; st[26:23] = hit; st[22] = ty; end
        chk(req, dmem[aw_ix(i)], bufa(i) | (i == 3 ? 32'h2 : 32'h0) | 32'h1);
        chk(req, dmem[aw_ix(i) + 1], st);
    endtask

    task automatic chk_bytes(input string req, input int i, input int seed, input int k0, input int n);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++)
            if (bmem[11'(bufa(i) + 32'(k))] !== 8'(seed + k0 + k)) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset in_ready", {31'd0, in_ready}, 32'd0);
        chk("R1 reset no writes", 32'(dwr_cnt + bwr_cnt), 32'd0);
        chk("R1 reset overrun", {31'd0, overrun}, 32'd0);
    endtask

    task automatic t_single;
        send_frame(60, 8'h10, 1'b1, 4'b0101, 1'b1);
        chk_desc("R2 R3 R5 R6 R7 single", 0, 1, 1, 60, 1, 4'b0101, 1);
        chk_bytes("R4 R12 single data", 0, 8'h10, 0, 60);
    endtask

    task automatic t_chain;
        send_frame(300, 8'h33, 1'b0, 4'h0, 1'b0);
        chk_desc("R5 R6 chain first", 1, 1, 0, 0, 0, 0, 0);
        chk_desc("R5 R6 chain middle", 2, 0, 0, 0, 0, 0, 0);
        chk_desc("R3 R6 chain last", 3, 0, 1, 300, 0, 0, 0);
        chk_bytes("R4 chain b1", 1, 8'h33, 0, 128);
        chk_bytes("R4 chain b3", 3, 8'h33, 256, 44);
    endtask

    task automatic t_exact;
        release_desc(0);
        send_frame(128, 8'h80, 1'b0, 4'b1000, 1'b0);
        chk_desc("R4 R8 exact 128 after wrap", 0, 1, 1, 128, 0, 4'b1000, 0);
        chk_bytes("R4 exact data", 0, 8'h80, 0, 128);
    endtask

    task automatic t_wrap_span;
        release_desc(1); release_desc(2);
        send_frame(256, 8'h05, 1'b0, 4'h0, 1'b1);
        chk_desc("R6 two buffers", 2, 0, 1, 256, 0, 0, 1);
        release_desc(3); release_desc(0);
        send_frame(200, 8'h61, 1'b1, 4'h0, 1'b0);
        chk_desc("R8 R3 span wrap first", 3, 1, 0, 0, 0, 0, 0);
        chk_desc("R8 span wrap last", 0, 0, 1, 200, 1, 0, 0);
        chk_bytes("R8 span tail data", 0, 8'h61, 128, 72);
    endtask

    task automatic t_overrun_start;
        int o0, w0, b0;
        o0 = ovr_cnt; w0 = dwr_cnt; b0 = bwr_cnt;
        send_frame(50, 8'hA0, 1'b0, 4'h0, 1'b0);
        chk("R9 one pulse", 32'(ovr_cnt - o0), 32'd1);
        chk("R9 no writes", 32'(dwr_cnt - w0 + bwr_cnt - b0), 32'd0);
        release_desc(1);
        send_frame(40, 8'hC0, 1'b0, 4'h2, 1'b0);
        chk_desc("R9 same desc retried", 1, 1, 1, 40, 0, 4'h2, 0);
        chk_bytes("R9 no leftover bytes", 1, 8'hC0, 0, 40);
    endtask

    task automatic t_disable;
        int w0;
        w0 = dwr_cnt + bwr_cnt;
        @(negedge clk);
        rx_en = 1'b0; in_valid = 1'b1; in_data = 8'h55;
        repeat (3) @(negedge clk);
        chk("R1 in_ready low when disabled", {31'd0, in_ready}, 32'd0);
        chk("R1 no access when disabled", 32'(dwr_cnt + bwr_cnt - w0), 32'd0);
        in_valid = 1'b0; rx_en = 1'b1;
        @(negedge clk);
        release_desc(0);
        send_frame(20, 8'h2E, 1'b0, 4'h0, 1'b0);
        chk_desc("R1 restart at desc 0", 0, 1, 1, 20, 0, 0, 0);
    endtask

    task automatic t_overrun_mid;
        int o0;
        logic [31:0] s2;
        release_desc(1);
        s2 = dmem[aw_ix(2) + 1];
        o0 = ovr_cnt;
        send_frame(200, 8'h90, 1'b1, 4'hF, 1'b1);
        chk("R10 one pulse", 32'(ovr_cnt - o0), 32'd1);
        chk_desc("R10 closed buffer kept", 1, 1, 0, 0, 0, 0, 0);
        chk("R10 owned desc untouched", dmem[aw_ix(2) + 1], s2);
        release_desc(2);
        send_frame(10, 8'h47, 1'b0, 4'h0, 1'b0);
        chk_desc("R10 resumes at owned desc", 2, 1, 1, 10, 0, 0, 0);
        chk("R11 writeback pairing", 32'(seq_err), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        for (int i = 0; i < 2048; i++) bmem[i] = '0;
        for (int i = 0; i < 4; i++) dmem[aw_ix(i)] = bufa(i) | (i == 3 ? 32'h2 : 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        @(negedge clk);
        t_single();
        t_chain();
        t_exact();
        t_wrap_span();
        t_overrun_start();
        t_disable();
        t_overrun_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule